// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Erase Engine

This block is the slave side of a three-wire serial EEPROM port, reduced to the parts that erase memory. A host drives a chip select, a serial clock and a serial data line. The block samples all three on its own system clock, assembles instruction frames and carries out two kinds of erase. One clears a single word to all ones. The other clears every word of the array to all ones. A small register array holds the data, so the effect of an erase can be read back over the same port.

An erase starts on the serial clock edge that samples the final address bit. From then on it runs by itself, timed in system-clock cycles, and needs no further serial clocks. A write-enable latch gates both erases. While an erase is running the block ignores every new frame. After an erase has started, the host can poll progress. It drops chip select for a minimum number of system cycles and raises it again. The data-out pin then drives 0 while the erase is busy and 1 once the erase is done. At all other times the pin is released, except while a read shifts out data.

Top module: `mw_erase_engine`

## Requirements
- R1: A single-word erase (start bit 1, opcode 11, then the address) sets every bit of the addressed word to 1 and leaves all other words unchanged.
- R2: An erase-all (start bit 1, opcode 00, address field starting with 10, remaining address bits don't-care) sets every word of the array to all ones.
- R3: A frame is a start bit of 1 followed by a 2-bit opcode and then ADDR_W address bits, each sent MSB first and sampled on the rising serial clock. Opcode 10 reads, opcode 11 erases one word, and opcode 00 selects a command by the top two address bits: 11 sets write-enable, 00 clears it, 10 erases all. Other opcode and command values do nothing.
- R4: An erase begins on the rising serial clock that samples the last address bit. It then stays busy for ERASE_CYC system cycles (single word) or ERAL_CYC system cycles (whole array), with no further serial clocks needed.
- R5: After an erase has started, chip select held low for at least CSL_MIN system cycles and then raised enables data-out. Data-out reads 0 while the erase runs and 1 once it is done. The status stays valid until chip select falls. Once ready has been reported and chip select falls, later raises show no status until another erase starts.
- R6: A chip-select low time shorter than CSL_MIN system cycles presents no status on the next raise.
- R7: Lowering chip select releases data-out within a few system cycles and discards any partly received frame.
- R8: An erase is carried out only while the write-enable latch is set. With the latch clear, the frame is decoded and ignored.
- R9: Frames that arrive while an erase is busy are ignored.
- R10: A read enables data-out and presents the addressed word MSB first. The first bit appears after the last address bit, and each later rising serial clock moves to the next bit. After reset, word i holds (37*i + 5) mod 2^DATA_W.
- R11: After reset, data-out is released and the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_in | input | 1 | Chip select from the host, active high |
| sck_in | input | 1 | Serial clock from the host |
| sdi_in | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |

## Verification
The hardest situation to reach is a frame that arrives while an erase is still running. The stimulus issues a single-word erase and at once sends a complete second erase frame to another address, well inside the erase time. It then waits for completion and reads both words back. A short chip-select pulse sent just before a valid one separates the minimum-low-time rule from ordinary status polling. The erase-all run is probed at a point past the single-word duration, so a timer that used the wrong count would report ready too early.

// File: rtl/mw_erase_pkg.sv
package mw_erase_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_READ,
        PH_HOLD
    } phase_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;
    localparam logic [1:0] OP_MISC  = 2'b00;

    localparam logic [1:0] SUB_WEN_ON  = 2'b11;
    localparam logic [1:0] SUB_WEN_OFF = 2'b00;
    localparam logic [1:0] SUB_ALL     = 2'b10;

endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] s1_q, s2_q, pv_q;
    logic [W-1:0] s1_d, s2_d, pv_d;

    always_comb begin
        s1_d = raw;
        s2_d = s1_q;
        pv_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            pv_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            pv_q <= pv_d;
        end
    end

    assign lvl  = s2_q;
    assign rise = s2_q & ~pv_q;

endmodule

// File: rtl/mw_erase_timer.sv
module mw_erase_timer #(
    parameter int ONE_CYC = 200,
    parameter int ALL_CYC = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_one,
    input  logic start_all,
    output logic busy
);
    localparam int MAXC = (ALL_CYC > ONE_CYC) ? ALL_CYC : ONE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_all)
            cnt_d = CW'(ALL_CYC);
        else if (start_one)
            cnt_d = CW'(ONE_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R4: a started erase is busy on the following cycle
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_one || start_all) |=> busy);

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_one,
    input  logic              clr_all,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];
    logic [DATA_W-1:0] words_d [DEPTH];

    always_comb begin
        words_d = words_q;
        if (clr_all) begin
            for (int i = 0; i < DEPTH; i++) words_d[i] = '1;
        end else if (clr_one) begin
            words_d[addr] = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= DATA_W'(i * 37 + 5);
        end else begin
            words_q <= words_d;
        end
    end

    assign rdata = words_q[addr];

    // R1: the addressed word holds all ones after a single-word erase
    a_r1_word_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_one |=> (words_q[$past(addr)] == '1));

    // R2: both ends of the array hold all ones after an erase-all
    a_r2_array_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (words_q[0] == '1 && words_q[DEPTH-1] == '1));

endmodule

// File: rtl/mw_erase_engine.sv
module mw_erase_engine
    import mw_erase_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int ERASE_CYC = 200,
    parameter int ERAL_CYC  = 600,
    parameter int CSL_MIN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_in,
    input  logic sck_in,
    input  logic sdi_in,
    output logic sdo,
    output logic sdo_oe
);
    localparam int FRAME = 2 + ADDR_W;
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam int CSL_W = $clog2(CSL_MIN + 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [FRAME-1:0]  sh;
        logic              wen;
        logic              stat;
        logic              arm;
        logic [DATA_W-1:0] rd;
        logic [CSL_W-1:0]  csl;
    } st_t;

    st_t q, d;

    logic [2:0]        lvl, rise;
    logic              cs, cs_rise, sck_rise, sdi;
    logic              busy;
    logic              go_one, go_all;
    logic [FRAME-1:0]  full;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        op, sub;
    logic [DATA_W-1:0] rdata;

    mw_sync_edge #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sdi_in, sck_in, cs_in}),
        .lvl  (lvl),
        .rise (rise)
    );

    assign cs       = lvl[0];
    assign cs_rise  = rise[0];
    assign sck_rise = rise[1];
    assign sdi      = lvl[2];

    assign full = {q.sh[FRAME-2:0], sdi};
    assign addr = full[ADDR_W-1:0];
    assign op   = full[FRAME-1 -: 2];
    assign sub  = full[ADDR_W-1 -: 2];

    always_comb begin
        d      = q;
        go_one = 1'b0;
        go_all = 1'b0;
        if (!cs) begin
            d.ph   = PH_IDLE;
            d.cnt  = '0;
            d.stat = 1'b0;
            if (q.stat && !busy) d.arm = 1'b0;
            if (q.csl != CSL_W'(CSL_MIN)) d.csl = q.csl + CSL_W'(1);
        end else begin
            d.csl = '0;
            if (cs_rise && (q.csl >= CSL_W'(CSL_MIN)) && (busy || q.arm))
                d.stat = 1'b1;
            if (sck_rise && !busy) begin
                unique case (q.ph)
                    PH_IDLE: if (sdi) begin
                        d.ph  = PH_SHIFT;
                        d.cnt = '0;
                    end
                    PH_SHIFT: begin
                        d.sh  = full;
                        d.cnt = q.cnt + CNT_W'(1);
                        if (q.cnt == CNT_W'(FRAME - 1)) begin
                            d.ph = PH_HOLD;
                            unique case (op)
                                OP_READ: begin
                                    d.ph = PH_READ;
                                    d.rd = rdata;
                                end
                                OP_ERASE: if (q.wen) begin
                                    go_one = 1'b1;
                                    d.arm  = 1'b1;
                                end
                                OP_MISC: begin
                                    if (sub == SUB_WEN_ON)  d.wen = 1'b1;
                                    if (sub == SUB_WEN_OFF) d.wen = 1'b0;
                                    if (sub == SUB_ALL && q.wen) begin
                                        go_all = 1'b1;
                                        d.arm  = 1'b1;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                    PH_READ: d.rd = {q.rd[DATA_W-2:0], 1'b0};
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    mw_erase_timer #(.ONE_CYC(ERASE_CYC), .ALL_CYC(ERAL_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_one(go_one),
        .start_all(go_all),
        .busy     (busy)
    );

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_one(go_one),
        .clr_all(go_all),
        .addr   (addr),
        .rdata  (rdata)
    );

    assign sdo_oe = q.stat || (q.ph == PH_READ);
    assign sdo    = q.stat ? !busy : q.rd[DATA_W-1];

    // R7: a deselected port releases data-out on the next cycle
    a_r7_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !sdo_oe);

    // R9: no erase is launched while one is still running
    a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !((go_one || go_all) && busy));

    // R8: an erase is launched only with write-enable set
    a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (go_one || go_all) |-> q.wen);

    // R5: status output turns on only after a chip-select rising edge
    a_r5_status_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stat) |-> $past(cs_rise));

endmodule

// File: tb/test_mw_erase_engine.sv
module test_mw_erase_engine;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int ERASE_CYC = 200;
    localparam int ERAL_CYC  = 600;
    localparam int CSL_MIN   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_in = 1'b0;
    logic sck_in = 1'b0;
    logic sdi_in = 1'b0;
    logic sdo, sdo_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mw_erase_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC),
        .ERAL_CYC(ERAL_CYC), .CSL_MIN(CSL_MIN)
    ) i_mw_erase_engine (
        .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .sck_in(sck_in),
        .sdi_in(sdi_in), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    function automatic logic [DATA_W-1:0] init_word(input int i);
        return DATA_W'(i * 37 + 5);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sdi_in = b;
        tick(4);
        sck_in = 1'b1;
        tick(4);
        sck_in = 1'b0;
    endtask

    task automatic send_frame(input logic [1:0] op, input logic [ADDR_W-1:0] a);
        cs_in = 1'b0;
        tick(8);
        cs_in = 1'b1;
        tick(2);
        bit_out(1'b1);
        bit_out(op[1]);
        bit_out(op[0]);
        for (int k = ADDR_W - 1; k >= 0; k--) bit_out(a[k]);
        sdi_in = 1'b0;
    endtask

    task automatic read_word(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        send_frame(2'b10, a);
        tick(4);
        v[DATA_W-1] = sdo;
        for (int j = DATA_W - 2; j >= 0; j--) begin
            sck_in = 1'b1;
            tick(4);
            v[j] = sdo;
            sck_in = 1'b0;
            tick(4);
        end
    endtask

    task automatic probe(input int low, output logic oe, output logic val);
        cs_in = 1'b0;
        tick(low);
        cs_in = 1'b1;
        tick(6);
        oe  = sdo_oe;
        val = sdo;
    endtask

    task automatic t_reset;
        logic oe, v;
        chk("R11 reset releases sdo", 32'(sdo_oe), 32'd0);
        probe(8, oe, v);
        chk("R5 no status without erase", 32'(oe), 32'd0);
    endtask

    task automatic t_read;
        logic [DATA_W-1:0] v;
        read_word(4'd0, v);
        chk("R10 read word 0", 32'(v), 32'(init_word(0)));
        chk("R10 read enables sdo", 32'(sdo_oe), 32'd1);
        read_word(4'd5, v);
        chk("R3 read word 5", 32'(v), 32'(init_word(5)));
        read_word(4'd15, v);
        chk("R10 read word 15", 32'(v), 32'(init_word(15)));
    endtask

    task automatic t_locked;
        logic [DATA_W-1:0] v;
        logic oe, s;
        send_frame(2'b11, 4'd3);
        probe(8, oe, s);
        chk("R11 write-enable clear: no status", 32'(oe), 32'd0);
        read_word(4'd3, v);
        chk("R8 erase ignored when locked", 32'(v), 32'(init_word(3)));
    endtask

    task automatic t_erase_one;
        logic [DATA_W-1:0] v;
        logic oe, s;
        send_frame(2'b00, 4'b1100);
        send_frame(2'b11, 4'd3);
        probe(8, oe, s);
        chk("R5 status enabled", 32'(oe), 32'd1);
        chk("R4 busy right after erase", 32'(s), 32'd0);
        tick(ERASE_CYC + 20);
        chk("R4 ready with no serial clocks", 32'(sdo), 32'd1);
        chk("R5 status still driven", 32'(sdo_oe), 32'd1);
        probe(8, oe, s);
        chk("R5 no status after ready reported", 32'(oe), 32'd0);
        read_word(4'd3, v);
        chk("R1 word 3 erased", 32'(v), 32'hFF);
        read_word(4'd2, v);
        chk("R1 word 2 untouched", 32'(v), 32'(init_word(2)));
        read_word(4'd4, v);
        chk("R1 word 4 untouched", 32'(v), 32'(init_word(4)));
    endtask

    task automatic t_short_csl;
        logic oe, s;
        send_frame(2'b11, 4'd6);
        probe(2, oe, s);
        chk("R6 short low time gives no status", 32'(oe), 32'd0);
        probe(8, oe, s);
        chk("R6 full low time gives status", 32'(oe), 32'd1);
        chk("R5 busy shown as 0", 32'(s), 32'd0);
        tick(ERASE_CYC + 20);
    endtask

    task automatic t_busy_ignore;
        logic [DATA_W-1:0] v;
        send_frame(2'b11, 4'd8);
        send_frame(2'b11, 4'd10);
        tick(ERASE_CYC + 50);
        read_word(4'd10, v);
        chk("R9 frame during busy ignored", 32'(v), 32'(init_word(10)));
        read_word(4'd8, v);
        chk("R1 word 8 erased", 32'(v), 32'hFF);
    endtask

    task automatic t_disable;
        logic [DATA_W-1:0] v;
        send_frame(2'b00, 4'b0000);
        send_frame(2'b11, 4'd12);
        tick(ERASE_CYC + 20);
        read_word(4'd12, v);
        chk("R8 erase after disable ignored", 32'(v), 32'(init_word(12)));
    endtask

    task automatic t_abort;
        logic [DATA_W-1:0] v;
        cs_in = 1'b0;
        tick(8);
        cs_in = 1'b1;
        tick(2);
        bit_out(1'b1);
        bit_out(1'b1);
        read_word(4'd5, v);
        chk("R7 partial frame discarded", 32'(v), 32'(init_word(5)));
        send_frame(2'b10, 4'd5);
        tick(4);
        chk("R10 readout active", 32'(sdo_oe), 32'd1);
        cs_in = 1'b0;
        tick(4);
        chk("R7 deselect releases sdo", 32'(sdo_oe), 32'd0);
    endtask

    task automatic t_erase_all;
        logic [DATA_W-1:0] v;
        logic oe, s;
        send_frame(2'b00, 4'b1100);
        send_frame(2'b00, 4'b1011);
        tick(ERASE_CYC + 50);
        probe(8, oe, s);
        chk("R4 erase-all longer than single", 32'(s), 32'd0);
        chk("R5 status during erase-all", 32'(oe), 32'd1);
        tick(ERAL_CYC - ERASE_CYC);
        chk("R4 erase-all completes", 32'(sdo), 32'd1);
        read_word(4'd0, v);
        chk("R2 word 0 erased", 32'(v), 32'hFF);
        read_word(4'd7, v);
        chk("R2 word 7 erased", 32'(v), 32'hFF);
        read_word(4'd15, v);
        chk("R2 word 15 erased", 32'(v), 32'hFF);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_read();
        t_locked();
        t_erase_one();
        t_short_csl();
        t_busy_ignore();
        t_disable();
        t_abort();
        t_erase_all();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule